// File: doc/BRIEF.md
# Single-Precision Floating-Point Multiplier

This block multiplies two 32-bit binary floating-point operands (one sign bit, an 8-bit biased exponent, a 23-bit fraction) and returns the product in the same layout one clock after the operands are presented. The sign, the exponent sum and the significand product are formed side by side. The significand product comes from a radix-4 recoded partial-product array. It is normalized with at most one right shift and then truncated. No rounding is applied. This suits a multiply-accumulate chain, where rounding belongs after the adder.

Any result that falls outside the normal exponent range is clamped. A result that is too small becomes zero with the computed sign and raises the underflow flag. A result that is too large becomes infinity with the computed sign and raises the overflow flag. An operand with a zero exponent field is treated as out of range, so the product becomes a signed zero with underflow. Callers pulse the input valid with a pair of operands and take the result on the following cycle, when the output valid is high.

Top module: `sp_fmul`

## Requirements
- R1: The sign bit of every result, including zero and infinity results, is the XOR of the two operand sign bits (bit 31).
- R2: For a normal result, let eSum = eA + eB − 127, using the exponent fields in bits 30..23. Let P be the 48-bit product of the two significands {1, fraction}. If P bit 47 is set, the result exponent is eSum + 1 and the fraction is P[46:24]. Otherwise the exponent is eSum and the fraction is P[45:23]. The fraction is truncated, never rounded.
- R3: When the input valid is high, the result, both flags and the output valid are updated at the next rising clock edge. In a cycle with the input valid low, the output valid goes low at the next edge, and the result and flags keep their previous values whatever the operands are.
- R4: If eSum is negative, the result is zero with the R1 sign (bits 30..0 all zero) and the underflow flag is set.
- R5: If eSum is exactly zero and P bit 47 is set, the result is normal with exponent field 1 and no flag. If eSum is zero and P bit 47 is clear, the result is underflow as in R4.
- R6: If the final exponent (eSum plus the normalization increment) is 255 or more, the result is infinity with the R1 sign: exponent field 0xFF, fraction zero, overflow flag set.
- R7: If either operand has exponent field 0, the result is zero with the R1 sign and the underflow flag is set. This takes priority over overflow.
- R8: Both flags are low for a normal result, whose exponent field lies in 1..254. The two flags are never high together.
- R9: While reset is asserted, the result, both flags and the output valid are zero.
- R10: An operand with exponent field 255 is not treated as special. It enters the exponent sum as the value 255 like any other field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Operands are presented this cycle |
| opA | input | 32 | First operand |
| opB | input | 32 | Second operand |
| result | output | 32 | Registered product |
| overflow | output | 1 | Result was clamped to infinity |
| underflow | output | 1 | Result was clamped to zero |
| outValid | output | 1 | Result and flags belong to the operands of the previous cycle |

## Verification
The hardest cases to reach are the two exponent-zero outcomes of R5. Both have an exponent sum of exactly 127, and they differ only in whether the significand product carries into bit 47. Uniform random operands almost never produce a sum of exactly 127. The stimulus therefore pairs exponent fields such as 63 and 64. It uses all-zero fractions for the underflow case and all-ones fractions for the rescue case. The same fraction trick is applied at an exponent sum of 381, where the shift moves a result of 254 up to 255 and into overflow. On top of these directed pairs, random exponent fields are drawn near the bias so that both clamps and the normal band are hit often.

// File: rtl/sp_fmul_pkg.sv
package sp_fmul_pkg;

  // outcome class computed by the datapath from its exponent and operands
  typedef struct packed {
    logic denormIn;  // an operand exponent field is zero
    logic expLow;    // final exponent at or below zero
    logic expHigh;   // final exponent at or above the all-ones code
  } class_t;

  // strobes from control into the datapath
  typedef struct packed {
    logic capture;
    logic forceZero;
    logic forceInf;
  } strobe_t;

endpackage

// File: rtl/sp_fmul_booth.sv
module sp_fmul_booth #(
  parameter int W = 24
) (
  input  logic [W-1:0]   mcand,
  input  logic [W-1:0]   mplier,
  output logic [2*W-1:0] prod
);
  localparam int PW     = 2 * W;
  localparam int GROUPS = (W + 2) / 2;
  localparam int EXT    = 2 * GROUPS + 1;

  // multiplier padded with an implicit zero below and zeros above (unsigned)
  logic [EXT-1:0] yExt;
  assign yExt = {{(EXT - W - 1){1'b0}}, mplier, 1'b0};

  logic [PW-1:0] pp [GROUPS];

  for (genvar g = 0; g < GROUPS; g++) begin : gen_pp
    logic [2:0]    trip;
    logic          isOne;
    logic          isTwo;
    logic          isNeg;
    logic [PW-1:0] mag;
    assign trip  = yExt[2*g+2 -: 3];
    assign isNeg = trip[2] & ~(trip[1] & trip[0]);
    assign isOne = trip[1] ^ trip[0];
    assign isTwo = (trip == 3'b011) | (trip == 3'b100);
    assign mag   = isOne ? (PW'(mcand) << (2 * g)) :
                   isTwo ? (PW'(mcand) << (2 * g + 1)) : '0;
    assign pp[g] = isNeg ? (~mag + 1'b1) : mag;
  end

  always_comb begin
    prod = '0;
    for (int i = 0; i < GROUPS; i++) prod = prod + pp[i];
  end

endmodule

// File: rtl/sp_fmul_dp.sv
module sp_fmul_dp
  import sp_fmul_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [EXP_W+FRAC_W:0]     opA,
  input  logic [EXP_W+FRAC_W:0]     opB,
  input  strobe_t                   strobe,
  output class_t                    cls,
  output logic [EXP_W+FRAC_W:0]     result
);
  localparam int WORD_W  = EXP_W + FRAC_W + 1;
  localparam int SIG_W   = FRAC_W + 1;
  localparam int PROD_W  = 2 * SIG_W;
  localparam int IE_W    = EXP_W + 2;
  localparam int SGN     = WORD_W - 1;
  localparam int BIAS    = (1 << (EXP_W - 1)) - 1;
  localparam int EXP_MAX = (1 << EXP_W) - 1;
  localparam logic signed [IE_W-1:0] BIAS_S = IE_W'(BIAS);
  localparam logic signed [IE_W-1:0] MAX_S  = IE_W'(EXP_MAX);

  logic [EXP_W-1:0]  expA, expB;
  logic [SIG_W-1:0]  sigA, sigB;
  logic [PROD_W-1:0] prod;
  logic [EXP_W:0]    expSum;
  logic signed [IE_W-1:0] intermExp, finalExp;
  logic              prodTop;
  logic [FRAC_W-1:0] fracOut;
  logic              signOut;

  assign expA    = opA[SGN-1 -: EXP_W];
  assign expB    = opB[SGN-1 -: EXP_W];
  assign sigA    = {1'b1, opA[FRAC_W-1:0]};
  assign sigB    = {1'b1, opB[FRAC_W-1:0]};
  assign signOut = opA[SGN] ^ opB[SGN];

  sp_fmul_booth #(.W(SIG_W)) u_booth (
    .mcand (sigA),
    .mplier(sigB),
    .prod  (prod)
  );

  // exponent path: carry-keeping sum, bias removal, normalization increment
  assign expSum    = {1'b0, expA} + {1'b0, expB};
  assign intermExp = $signed({{(IE_W - EXP_W - 1){1'b0}}, expSum}) - BIAS_S;
  assign prodTop   = prod[PROD_W-1];
  assign finalExp  = intermExp + $signed({{(IE_W - 1){1'b0}}, prodTop});

  // truncated fraction just below the leading one
  assign fracOut = prodTop ? prod[PROD_W-2 -: FRAC_W] : prod[PROD_W-3 -: FRAC_W];

  assign cls.denormIn = (expA == '0) | (expB == '0);
  assign cls.expLow   = (finalExp <= $signed(IE_W'(0)));
  assign cls.expHigh  = (finalExp >= MAX_S);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      result <= '0;
    end else if (strobe.capture) begin
      if (strobe.forceZero)
        result <= {signOut, {(WORD_W - 1){1'b0}}};
      else if (strobe.forceInf)
        result <= {signOut, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
      else
        result <= {signOut, finalExp[EXP_W-1:0], fracOut};
    end
  end

  // R2: recoded array matches an exact product of the significands
  a_r2_booth_exact: assert property (@(posedge clk) disable iff (!rstN)
    prod == PROD_W'(sigA) * PROD_W'(sigB));

  // R1: registered sign is the XOR of the captured operand signs
  a_r1_sign_xor: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capture |=> result[SGN] == $past(opA[SGN] ^ opB[SGN]));

  // R4: a zero clamp leaves magnitude bits clear
  a_r4_zero_clamp: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.capture && strobe.forceZero) |=> result[SGN-1:0] == '0);

  // R6: an infinity clamp gives all-ones exponent and empty fraction
  a_r6_inf_clamp: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.capture && strobe.forceInf) |=>
      result[SGN-1:0] == {{EXP_W{1'b1}}, {FRAC_W{1'b0}}});

  // R8: an unclamped capture yields an exponent field in the normal band
  a_r8_normal_band: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.capture && !strobe.forceZero && !strobe.forceInf) |=>
      (result[SGN-1 -: EXP_W] != '0) && (result[SGN-1 -: EXP_W] != {EXP_W{1'b1}}));

endmodule

// File: rtl/sp_fmul_ctrl.sv
module sp_fmul_ctrl
  import sp_fmul_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    inValid,
  input  class_t  cls,
  output strobe_t strobe,
  output logic    overflow,
  output logic    underflow,
  output logic    outValid
);
  // zero clamp outranks the infinity clamp
  assign strobe.capture   = inValid;
  assign strobe.forceZero = cls.denormIn | cls.expLow;
  assign strobe.forceInf  = ~(cls.denormIn | cls.expLow) & cls.expHigh;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      overflow  <= 1'b0;
      underflow <= 1'b0;
      outValid  <= 1'b0;
    end else begin
      outValid <= inValid;
      if (inValid) begin
        overflow  <= strobe.forceInf;
        underflow <= strobe.forceZero;
      end
    end
  end

  // R8: flags are mutually exclusive
  a_r8_flags_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(overflow && underflow));

  // R3: output valid tracks the input valid one cycle later
  a_r3_valid_follows: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
  a_r3_valid_drops: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);

  // R3: flags hold while no operands are presented
  a_r3_flags_hold: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> ($stable(overflow) && $stable(underflow)));

  // R7: a zero-exponent operand never produces an overflow
  a_r7_denorm_priority: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && cls.denormIn) |=> (underflow && !overflow));

endmodule

// File: rtl/sp_fmul.sv
module sp_fmul
  import sp_fmul_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  inValid,
  input  logic [EXP_W+FRAC_W:0] opA,
  input  logic [EXP_W+FRAC_W:0] opB,
  output logic [EXP_W+FRAC_W:0] result,
  output logic                  overflow,
  output logic                  underflow,
  output logic                  outValid
);
  class_t  cls;
  strobe_t strobe;

  sp_fmul_dp #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_dp (
    .clk   (clk),
    .rstN  (rstN),
    .opA   (opA),
    .opB   (opB),
    .strobe(strobe),
    .cls   (cls),
    .result(result)
  );

  sp_fmul_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .cls      (cls),
    .strobe   (strobe),
    .overflow (overflow),
    .underflow(underflow),
    .outValid (outValid)
  );

endmodule

// File: tb/sp_fmul_bench.sv
`timescale 1ns/1ps
module sp_fmul_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [31:0] opA = '0, opB = '0;
  logic [31:0] result;
  logic        overflow, underflow, outValid;

  int errors = 0;
  int checks = 0;

  // expected outputs, kept behaviourally
  logic [31:0] expRes = '0;
  bit          expOvf = 0, expUnf = 0, expVal = 0;

  always #5 clk = ~clk;

  sp_fmul u_sp_fmul (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opA(opA), .opB(opB),
    .result(result), .overflow(overflow), .underflow(underflow), .outValid(outValid)
  );

  function automatic void refModel(input logic [31:0] a, input logic [31:0] b,
                                   output logic [31:0] r, output bit of, output bit uf);
    bit s;
    int ea, eb, e;
    longint ma, mb, p;
    logic [22:0] fr;
    s  = a[31] ^ b[31];
    ea = int'(a[30:23]);
    eb = int'(b[30:23]);
    of = 0; uf = 0;
    if (ea == 0 || eb == 0) begin
      uf = 1; r = {s, 31'd0}; return;
    end
    ma = longint'({1'b1, a[22:0]});
    mb = longint'({1'b1, b[22:0]});
    p  = ma * mb;
    e  = ea + eb - 127;
    if (p >= (longint'(1) << 47)) begin
      e  = e + 1;
      fr = 23'((p >> 24) & 64'h7FFFFF);
    end else begin
      fr = 23'((p >> 23) & 64'h7FFFFF);
    end
    if (e <= 0) begin
      uf = 1; r = {s, 31'd0};
    end else if (e >= 255) begin
      of = 1; r = {s, 8'hFF, 23'd0};
    end else begin
      r = {s, 8'(e), fr};
    end
  endfunction

  task automatic compare(input string tag);
    checks++;
    if (outValid !== expVal || result !== expRes ||
        overflow !== expOvf || underflow !== expUnf) begin
      errors++;
      $display("FAIL %s: got val=%0b res=%h ovf=%0b unf=%0b expected val=%0b res=%h ovf=%0b unf=%0b",
               tag, outValid, result, overflow, underflow, expVal, expRes, expOvf, expUnf);
    end
  endtask

  // called at a falling edge; applies one cycle of stimulus and checks after the next rising edge
  task automatic step(input logic [31:0] a, input logic [31:0] b, input bit v, input string tag);
    logic [31:0] r;
    bit of, uf;
    opA = a; opB = b; inValid = v;
    @(posedge clk);
    if (v) begin
      refModel(a, b, r, of, uf);
      expRes = r; expOvf = of; expUnf = uf;
    end
    expVal = v;
    @(negedge clk);
    compare(tag);
  endtask

  function automatic logic [31:0] fp(input bit s, input int e, input int f);
    return {s, 8'(e), 23'(f)};
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    compare("R9 reset state");
    rstN = 1'b1;
    @(negedge clk);
    compare("R9 after release");

    step(32'h40000000, 32'h40400000, 1, "R2 two times three");
    step(32'h42200000, 32'hC0F00000, 1, "R1 R2 forty times minus seven point five");
    step(32'h12345678, 32'h87654321, 0, "R3 idle cycle holds result");
    step(32'h3F800000, 32'h3F800000, 1, "R2 one times one");
    step(fp(1, 63, 0), fp(1, 64, 0), 1, "R5 zero exponent unrescued underflow");
    step(fp(0, 63, 23'h7FFFFF), fp(1, 64, 23'h7FFFFF), 1, "R5 zero exponent rescued to one");
    step(fp(0, 64, 0), fp(0, 64, 0), 1, "R2 exponent one boundary");
    step(fp(1, 1, 5), fp(0, 1, 9), 1, "R4 negative exponent underflow");
    step(fp(0, 200, 0), fp(0, 181, 0), 1, "R2 exponent 254 boundary");
    step(fp(1, 200, 23'h7FFFFF), fp(0, 181, 23'h7FFFFF), 1, "R6 shift pushes 254 to overflow");
    step(32'h0, 32'h0, 0, "R3 idle holds overflow flag");
    step(fp(0, 200, 0), fp(1, 182, 0), 1, "R6 exponent 255 overflow");
    step(fp(1, 254, 23'h7FFFFF), fp(1, 254, 23'h7FFFFF), 1, "R6 largest operands");
    step(fp(0, 0, 23'h400000), fp(1, 254, 0), 1, "R7 zero-exponent operand outranks overflow");
    step(32'h80000000, 32'h3F800000, 1, "R7 R1 negative zero operand");
    step(fp(0, 255, 0), fp(0, 1, 0), 1, "R10 all-ones exponent as ordinary value");
    step(32'h3F800000, 32'h40000000, 1, "R8 flags clear on normal result");

    for (int i = 0; i < 600; i++) begin
      logic [31:0] a, b;
      int ea, eb;
      if (i % 3 == 0) begin
        ea = int'($urandom_range(0, 255));
        eb = int'($urandom_range(0, 255));
      end else begin
        ea = 40 + int'($urandom_range(0, 150));
        eb = 40 + int'($urandom_range(0, 150));
      end
      a = fp(bit'($urandom_range(0, 1)), ea, int'($urandom_range(0, 32'h7FFFFF)));
      b = fp(bit'($urandom_range(0, 1)), eb, int'($urandom_range(0, 32'h7FFFFF)));
      step(a, b, (i % 11) != 5, "R2 R3 R4 R6 R8 random");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule